// File: doc/BRIEF.md
# Burst Request Handshake Engine

This block is the application-facing front end of a synchronous DRAM controller. An application raises a request that carries a 22-bit address, a direction and an 8-bit word count. The engine answers with a one-cycle acknowledge and then paces a burst of 36-bit words, each four data bytes plus four parity bits, between the application and a memory-side stub port.

The memory side sees a row phase followed by a data phase. In the row phase the engine presents the bank and row. In the data phase it presents a column that advances by one per accepted word. The stub answers each phase with a ready bit. For writes the engine pulls words from the application one at a time. For reads it registers each returned word and marks it valid for one cycle. One-cycle strobes mark the last word in each direction. Refresh and initialization belong to other blocks; this engine only waits on an external init-done level.

Top module: `burst_req_engine`

## Requirements
- R1: `reqAck` goes high for exactly one cycle, in the cycle after a rising clock edge at which the engine was idle, `initDone` was high and `reqValid` was high.
- R2: While `initDone` is low, no request is acknowledged and the memory side stays idle (`memValid` low).
- R3: No acknowledge is given while a burst is in progress, even if `reqValid` stays high.
- R4: After an acknowledge, the row phase drives `memActivate` high, `memBank` with request address bits [21:20] and `memAddr` with address bits [19:8]. These stay unchanged until a cycle with `memReady` high.
- R5: In the data phase, `memAddr` carries the column zero-extended to 12 bits. The column starts at address bits [7:0] and increments modulo 256 after each cycle with `memReady` high.
- R6: `reqWrite` high selects a write. In a write data phase, `memWrData` equals `wrData`, `memMask` is the bitwise inverse of `byteEn`, and `memWrite` is high. `wrNext` is high exactly in the cycles where a write word is accepted (`memReady` high); the first word is taken from `wrData` as presented with the request.
- R7: `wrLast` is high only in the cycle that accepts the final write word.
- R8: For a read, `rdValid` is high in the cycle after each accepted read word, and `rdData` then holds the `memRdData` value from the accepting cycle. In all other cycles `rdValid` is low.
- R9: `rdLast` is high only together with the `rdValid` of the final read word.
- R10: A word count of N from 1 to 255 moves exactly N words. A count of 0 moves 256 words. After the final word the engine returns to idle (`memValid` low).
- R11: An active-low asynchronous reset clears every output strobe and returns the engine to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| initDone | input | 1 | Memory initialization complete |
| reqValid | input | 1 | Transfer request, held until acknowledged |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqAddr | input | 22 | Bank [21:20], row [19:8], column [7:0] |
| reqCount | input | 8 | Word count, 0 means 256 |
| wrData | input | 36 | Current write word |
| byteEn | input | 4 | Write byte enables, 1 = byte valid |
| reqAck | output | 1 | One-cycle request acknowledge |
| wrNext | output | 1 | Current write word consumed, present the next one |
| wrLast | output | 1 | Final write word consumed |
| rdData | output | 36 | Registered read word |
| rdValid | output | 1 | `rdData` is valid this cycle |
| rdLast | output | 1 | `rdData` is the final read word |
| memValid | output | 1 | Engine drives a row or data phase |
| memActivate | output | 1 | Row phase |
| memWrite | output | 1 | Data phase is a write |
| memBank | output | 2 | Bank select |
| memAddr | output | 12 | Row in the row phase, column in the data phase |
| memWrData | output | 36 | Write word toward memory |
| memMask | output | 4 | Byte masks, 1 = byte blocked |
| memReady | input | 1 | Memory side accepts the current phase |
| memRdData | input | 36 | Read word, sampled when a read word is accepted |

## Verification
The assertions assume that `memReady` is meaningful only while `memValid` is high, and that `memRdData` is valid in the same cycle as an accepted read word. They also assume the application drops `reqValid` in the cycle after it sees the acknowledge, unless it is deliberately holding it high to probe R3. The stimulus drives a memory stub that raises `memReady` only inside a burst, following an 8-bit ready pattern per burst, and it gives the new read word with each cycle. It releases `reqValid` before the final word, so that a held request is never taken as a second request once the engine is idle again.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_DATA = 2'd2
  } burstState_e;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic load;      // capture request fields
    logic rowPhase;  // row/bank phase active
    logic dataPhase; // column/data phase active
    logic beat;      // a data word is accepted this cycle
    logic last;      // the accepted word is the final one
    logic isWrite;   // direction of the burst in progress
  } burstStrobe_t;

endpackage

// File: rtl/burst_ctl.sv
`timescale 1ns/1ps
module burst_ctl
  import burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initDone,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             memReady,
  output burstStrobe_t     strobe,
  output logic             reqAck,
  output logic             memValid
);

  localparam logic [CNT_W:0] FULL_BURST = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] ONE_LEFT   = (CNT_W+1)'(1);

  burstState_e    stateQ;
  logic [CNT_W:0] remainQ;
  logic           writeQ;
  logic           ackQ;

  always_comb begin
    strobe.load      = (stateQ == ST_IDLE) && reqValid && initDone;
    strobe.rowPhase  = (stateQ == ST_ROW);
    strobe.dataPhase = (stateQ == ST_DATA);
    strobe.beat      = strobe.dataPhase && memReady;
    strobe.last      = strobe.beat && (remainQ == ONE_LEFT);
    strobe.isWrite   = writeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      remainQ <= '0;
      writeQ  <= 1'b0;
      ackQ    <= 1'b0;
    end else begin
      ackQ <= strobe.load;
      unique case (stateQ)
        ST_IDLE: if (strobe.load) begin
          writeQ  <= reqWrite;
          remainQ <= (reqCount == '0) ? FULL_BURST : {1'b0, reqCount};
          stateQ  <= ST_ROW;
        end
        ST_ROW: if (memReady) stateQ <= ST_DATA;
        ST_DATA: if (strobe.beat) begin
          remainQ <= remainQ - ONE_LEFT;
          if (strobe.last) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign reqAck   = ackQ;
  assign memValid = (stateQ != ST_IDLE);

endmodule

// File: rtl/burst_dp.sv
`timescale 1ns/1ps
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int MA_W   = 12,
  parameter int DATA_W = 36,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTES-1:0]  byteEn,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memActivate,
  output logic              memWrite,
  output logic [BANK_W-1:0] memBank,
  output logic [MA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [BYTES-1:0]  memMask,
  output logic              wrNext,
  output logic              wrLast,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdLast
);

  localparam int ROW_W = ADDR_W - BANK_W - COL_W;
  localparam int ROW_LO = COL_W;
  localparam int BANK_LO = COL_W + ROW_W;

  logic [BANK_W-1:0] bankQ;
  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic              readBeat;

  assign readBeat = strobe.beat && !strobe.isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ   <= '0;
      rowQ    <= '0;
      colQ    <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
      rdLast  <= 1'b0;
    end else begin
      if (strobe.load) begin
        bankQ <= reqAddr[BANK_LO +: BANK_W];
        rowQ  <= reqAddr[ROW_LO +: ROW_W];
        colQ  <= reqAddr[0 +: COL_W];
      end else if (strobe.beat) begin
        colQ <= colQ + COL_W'(1);
      end
      rdValid <= readBeat;
      rdLast  <= readBeat && strobe.last;
      if (readBeat) rdData <= memRdData;
    end
  end

  always_comb begin
    memActivate = strobe.rowPhase;
    memWrite    = strobe.dataPhase && strobe.isWrite;
    memBank     = bankQ;
    memAddr     = strobe.rowPhase ? MA_W'(rowQ) : MA_W'(colQ);
    memWrData   = wrData;
    memMask     = ~byteEn;
    wrNext      = strobe.beat && strobe.isWrite;
    wrLast      = strobe.last && strobe.isWrite;
  end

endmodule

// File: rtl/burst_req_engine.sv
`timescale 1ns/1ps
module burst_req_engine
  import burst_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int MA_W   = 12,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 36,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDone,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTES-1:0]  byteEn,
  output logic              reqAck,
  output logic              wrNext,
  output logic              wrLast,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdLast,
  output logic              memValid,
  output logic              memActivate,
  output logic              memWrite,
  output logic [BANK_W-1:0] memBank,
  output logic [MA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [BYTES-1:0]  memMask,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdData
);

  burstStrobe_t strobe;

  burst_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .initDone (initDone),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqCount (reqCount),
    .memReady (memReady),
    .strobe   (strobe),
    .reqAck   (reqAck),
    .memValid (memValid)
  );

  burst_dp #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .MA_W(MA_W), .DATA_W(DATA_W), .BYTES(BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .wrData      (wrData),
    .byteEn      (byteEn),
    .memRdData   (memRdData),
    .memActivate (memActivate),
    .memWrite    (memWrite),
    .memBank     (memBank),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .memMask     (memMask),
    .wrNext      (wrNext),
    .wrLast      (wrLast),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .rdLast      (rdLast)
  );

endmodule

// File: rtl/burst_req_checker.sv
`timescale 1ns/1ps
module burst_req_checker #(
  parameter int MA_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            initDone,
  input logic            reqAck,
  input logic            memValid,
  input logic            memActivate,
  input logic            memWrite,
  input logic            memReady,
  input logic [MA_W-1:0] memAddr,
  input logic            wrNext,
  input logic            wrLast,
  input logic            rdValid,
  input logic            rdLast
);

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck); // R1

  AST_ACK_AFTER_INIT: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> $past(initDone)); // R2

  AST_ACK_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (memActivate && !$past(memValid))); // R3

  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memActivate && !memReady) |=> (memActivate && $stable(memAddr))); // R4

  AST_WRNEXT_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    wrNext |-> (memReady && memWrite)); // R6

  AST_WRLAST_WITH_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    wrLast |-> wrNext); // R7

  AST_RDVALID_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(memValid && memReady && !memActivate && !memWrite)); // R8

  AST_RDLAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid); // R9

endmodule

bind burst_req_engine burst_req_checker #(.MA_W(MA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .initDone    (initDone),
  .reqAck      (reqAck),
  .memValid    (memValid),
  .memActivate (memActivate),
  .memWrite    (memWrite),
  .memReady    (memReady),
  .memAddr     (memAddr),
  .wrNext      (wrNext),
  .wrLast      (wrLast),
  .rdValid     (rdValid),
  .rdLast      (rdLast)
);

// File: tb/tb_burst_req_engine.sv
`timescale 1ns/1ps
module tb_burst_req_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initDone = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [7:0]  reqCount = '0;
  logic [35:0] wrData = '0;
  logic [3:0]  byteEn = '0;
  logic        reqAck, wrNext, wrLast, rdValid, rdLast;
  logic [35:0] rdData, memWrData, memRdData = '0;
  logic        memValid, memActivate, memWrite, memReady = 1'b0;
  logic [1:0]  memBank;
  logic [11:0] memAddr;
  logic [3:0]  memMask;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burst_req_engine dut (
    .clk(clk), .rstN(rstN), .initDone(initDone), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqCount(reqCount),
    .wrData(wrData), .byteEn(byteEn), .reqAck(reqAck), .wrNext(wrNext),
    .wrLast(wrLast), .rdData(rdData), .rdValid(rdValid), .rdLast(rdLast),
    .memValid(memValid), .memActivate(memActivate), .memWrite(memWrite),
    .memBank(memBank), .memAddr(memAddr), .memWrData(memWrData),
    .memMask(memMask), .memReady(memReady), .memRdData(memRdData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] wordOf(input logic [21:0] a, input int i, input bit rd);
    logic [35:0] w;
    w = {4'(i ^ 9), 32'h5A3C0000 ^ {10'b0, a} ^ (32'(i) * 32'h0001_9E37)};
    return rd ? ~w : w;
  endfunction

  // {hold, write, addr, count, readyPattern}
  localparam logic [39:0] VECS [8] = '{
    {1'b0, 1'b1, 22'h312345, 8'd5,   8'b1011_0111},
    {1'b0, 1'b0, 22'h0ABC10, 8'd6,   8'hFF},
    {1'b0, 1'b1, 22'h2000FE, 8'd4,   8'h55},
    {1'b1, 1'b0, 22'h1FFFFD, 8'd3,   8'b1100_1101},
    {1'b0, 1'b1, 22'h000000, 8'd1,   8'hFF},
    {1'b1, 1'b1, 22'h300080, 8'd7,   8'h0F},
    {1'b0, 1'b0, 22'h3ABCFF, 8'd0,   8'hFF},
    {1'b0, 1'b1, 22'h123400, 8'd0,   8'b1110_1111}
  };

  task automatic doBurst(input bit hold, input bit wr, input logic [21:0] a,
                         input logic [7:0] c, input logic [7:0] rdy);
    int n;
    int beat;
    int cyc;
    bit acc;
    bit lastAcc;
    n = (c == 8'd0) ? 256 : int'(c);
    beat = 0;
    cyc = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqCount = c;
    wrData = wordOf(a, 0, 0); byteEn = 4'(a);
    memReady = 1'b0;
    @(negedge clk);
    chk(reqAck === 1'b1, "R1 ack", 64'(reqAck), 1);
    if (!hold) reqValid = 1'b0;
    #1;
    chk(memActivate === 1'b1 && memBank === a[21:20], "R4 bank", 64'(memBank), 64'(a[21:20]));
    chk(memAddr === a[19:8], "R4 row", 64'(memAddr), 64'(a[19:8]));
    chk(rdValid === 1'b0, "R8 idle rdValid", 64'(rdValid), 0);
    @(negedge clk);
    chk(reqAck === 1'b0, "R1 ack pulse", 64'(reqAck), 0);
    chk(memActivate === 1'b1 && memAddr === a[19:8], "R4 row held", 64'(memAddr), 64'(a[19:8]));
    memReady = 1'b1;
    @(negedge clk);
    while (beat < n) begin
      memReady = rdy[cyc % 8];
      reqValid = hold && (beat < n - 1);
      memRdData = wordOf(a, beat, 1);
      #1;
      chk(memValid && !memActivate && memAddr === 12'((a[7:0] + beat) & 8'hFF),
          "R5 column", 64'(memAddr), 64'((a[7:0] + beat) & 8'hFF));
      if (wr) begin
        chk(memWrite === 1'b1 && memWrData === wordOf(a, beat, 0), "R6 wrdata",
            64'(memWrData), 64'(wordOf(a, beat, 0)));
        chk(memMask === ~byteEn, "R6 mask", 64'(memMask), 64'(~byteEn));
        chk(wrNext === memReady, "R6 wrNext", 64'(wrNext), 64'(memReady));
        chk(wrLast === (memReady && beat == n - 1), "R7 wrLast", 64'(wrLast),
            64'(memReady && beat == n - 1));
      end else begin
        chk(wrNext === 1'b0 && memWrite === 1'b0, "R6 read no wrNext", 64'(wrNext), 0);
      end
      acc = memReady;
      lastAcc = memReady && (beat == n - 1);
      @(negedge clk);
      chk(reqAck === 1'b0, "R3 no ack in burst", 64'(reqAck), 0);
      if (!wr && acc) begin
        chk(rdValid === 1'b1 && rdData === wordOf(a, beat, 1), "R8 rdData",
            64'(rdData), 64'(wordOf(a, beat, 1)));
        chk(rdLast === lastAcc, "R9 rdLast", 64'(rdLast), 64'(lastAcc));
      end else begin
        chk(rdValid === 1'b0 && rdLast === 1'b0, "R8 rdValid low", 64'(rdValid), 0);
      end
      if (acc) begin
        beat++;
        wrData = wordOf(a, beat, 0);
        byteEn = 4'(a + 22'(beat));
      end
      cyc++;
    end
    memReady = 1'b0;
    reqValid = 1'b0;
    chk(memValid === 1'b0, "R10 idle after count", 64'(memValid), 0);
    @(negedge clk);
    chk(rdValid === 1'b0 && memValid === 1'b0, "R10 stays idle", 64'(memValid), 0);
  endtask

  initial begin
    #1;
    chk(reqAck === 0 && memValid === 0 && rdValid === 0 && wrNext === 0,
        "R11 reset state", 64'({reqAck, memValid, rdValid, wrNext}), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R2: request while init not done
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 22'h1; reqCount = 8'd1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(reqAck === 1'b0 && memValid === 1'b0, "R2 blocked", 64'({reqAck, memValid}), 0);
    end
    reqValid = 1'b0;
    initDone = 1'b1;
    @(negedge clk);
    chk(reqAck === 1'b0, "R1 no ack without req", 64'(reqAck), 0);
    // vector table
    for (int v = 0; v < 8; v++) begin
      doBurst(VECS[v][39], VECS[v][38], VECS[v][37:16], VECS[v][15:8], VECS[v][7:0]);
    end
    // R11: reset in the middle of a write burst
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 22'h0F0F0F; reqCount = 8'd9;
    @(negedge clk);
    reqValid = 1'b0; memReady = 1'b1;
    @(negedge clk);
    #1;
    chk(wrNext === 1'b1, "R6 mid burst wrNext", 64'(wrNext), 1);
    rstN = 1'b0;
    #1;
    chk(memValid === 0 && wrNext === 0 && reqAck === 0 && rdValid === 0,
        "R11 async reset", 64'({memValid, wrNext, reqAck, rdValid}), 0);
    memReady = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(memValid === 1'b0, "R11 idle after reset", 64'(memValid), 0);
    doBurst(1'b0, 1'b0, 22'h2FF0FE, 8'd2, 8'hFF);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule